// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog Timer

This block is a watchdog timer for a system-clock domain. A one-cycle slow-clock enable, nominally at 32768 Hz, drives a prescaler. The prescaler divides by `DIV`, which defaults to 128. Each prescaler wrap decrements a 12-bit down-counter. With the defaults, a reload value of 0xFFF gives roughly 16 seconds before expiry. When the counter runs out, the block raises a one-cycle reset request, flags the event and keeps running.

Software reaches the block over a simple single-cycle register bus. The bus has three registers:

- **Control** (address 0, write-only) takes commands. A command acts only when it carries the correct key.
- **Mode** (address 1) holds the reload value, the window delta and a disable bit. Clearing the disable bit starts the timer and always reloads the counter. A keyed lock command freezes this register until hardware reset.
- **Status** (address 2) records three events: underflow, window violation, and a mode change made too soon after a restart. The status bits clear when the register is read.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, mode reads 0x0FFF8FFF (reload 0xFFF, delta 0xFFF, timer disabled). Status reads 0. `fault_o` and `rst_req_o` are low.
- R2: The mode register has three fields: reload in bits 11:0, disable in bit 15 and window delta in bits 27:16. A mode write stores those fields. A mode read returns them with every other bit zero. Reads of address 0 or 3 return 0.
- R3: A mode write that clears bit 15 while the stored disable bit is set loads the counter from the reload field being written. This holds even when the previous fields were all zero. The same write clears the prescaler.
- R4: While enabled, the counter decrements once every `DIV` slow enables. When it would reach zero, three things happen: status bit 0 sets, the counter reloads, and `rst_req_o` is high for exactly one cycle, one cycle later. Expiry comes about reload × `DIV` slow enables after the last reload.
- R5: A control write restarts the counter and clears the prescaler when two conditions hold: bits 31:24 equal 0xA5 and bit 0 is 1. A control write with any other key value has no effect.
- R6: A keyed control write with bit 4 set locks the mode register. After that, mode writes have no effect until `rst_ni` is asserted. A lock with a wrong key is ignored.
- R7: A keyed restart accepted while the timer is enabled and the counter is above the window delta sets status bit 1.
- R8: A mode write that changes the reload or delta field before 3 slow enables have passed since the last keyed restart sets status bit 2. The write is still applied.
- R9: Reading status returns bits {hazard, window, underflow} in bits 2:0 and clears them. An event in the same cycle as the read leaves its bit set. `fault_o` is high whenever status bit 0 or bit 1 is set.
- R10: While disabled, the counter and prescaler hold, and no underflow or reset request occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_en_i | input | 1 | One-cycle slow-clock enable |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Bus write (1) or read (0) |
| addr_i | input | 2 | Register select: 0 control, 1 mode, 2 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read, 0 otherwise |
| fault_o | output | 1 | Underflow or window-violation flag pending |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The key scenario enables the timer after all mode fields were zero. A design that skips the reload on enable would fire almost at once or never, so the bench measures the exact time to expiry. Restarts with a bad key are mixed between good ones. A block that checks only the restart bit would never expire. A lock command is followed by mode writes and then a reset. A lock that leaks, or that survives reset, changes the mode read-back. Status reads issued every cycle while the counter expires catch a clear that wins over a coincident event. Writes just after a restart, and later ones, catch a hazard window of the wrong length.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned FW = 12;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_MODE = 2'd1,
    A_STAT = 2'd2
  } wd_addr_e;

  typedef struct packed {
    logic [FW-1:0] delta;
    logic          dis;
    logic [FW-1:0] reload;
  } wd_mode_t;

  typedef struct packed {
    logic hazard;
    logic werr;
    logic unf;
  } wd_stat_t;

  localparam wd_mode_t MODE_RST = '{delta: '1, dis: 1'b1, reload: '1};

  function automatic wd_mode_t unpack_mode(logic [31:0] w);
    wd_mode_t m;
    m.reload = w[FW-1:0];
    m.dis    = w[15];
    m.delta  = w[16 +: FW];
    return m;
  endfunction

  function automatic logic [31:0] pack_mode(wd_mode_t m);
    logic [31:0] w;
    w            = '0;
    w[FW-1:0]    = m.reload;
    w[15]        = m.dis;
    w[16 +: FW]  = m.delta;
    return w;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter logic [7:0] KEY      = 8'hA5,
  parameter int unsigned HZ_TICKS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output wd_mode_t          mode_o,
  output logic              locked_o,
  output logic              enable_evt_o,
  output logic              restart_o,
  output logic [FW-1:0]     load_val_o,
  output logic              hazard_evt_o,
  output logic              stat_rd_o
);
  localparam int unsigned HW = $clog2(HZ_TICKS + 1);

  wd_mode_t       mode_q, mode_nx;
  logic           lock_q;
  logic [HW-1:0]  hz_q;
  logic           ctrl_wr, key_ok, lock_cmd, mode_wr, in_window;

  assign ctrl_wr   = req_i && we_i && (addr_i == A_CTRL);
  assign key_ok    = (wdata_i[31:24] == KEY);
  assign restart_o = ctrl_wr && key_ok && wdata_i[0];
  assign lock_cmd  = ctrl_wr && key_ok && wdata_i[4];
  assign mode_wr   = req_i && we_i && (addr_i == A_MODE) && !lock_q;
  assign mode_nx   = unpack_mode(wdata_i);
  assign stat_rd_o = req_i && !we_i && (addr_i == A_STAT);

  assign enable_evt_o = mode_wr && mode_q.dis && !mode_nx.dis;
  assign load_val_o   = enable_evt_o ? mode_nx.reload : mode_q.reload;
  assign in_window    = (hz_q < HW'(HZ_TICKS));
  assign hazard_evt_o = mode_wr && in_window &&
                        ((mode_nx.reload != mode_q.reload) || (mode_nx.delta != mode_q.delta));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      lock_q <= 1'b0;
      hz_q   <= HW'(HZ_TICKS);
    end else begin
      if (mode_wr) mode_q <= mode_nx;
      if (lock_cmd) lock_q <= 1'b1;
      if (restart_o) hz_q <= '0;
      else if (slow_en_i && in_window) hz_q <= hz_q + 1'b1;
    end
  end

  assign mode_o   = mode_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned DIV = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slow_en_i,
  input  wd_mode_t      mode_i,
  input  logic          enable_evt_i,
  input  logic          restart_i,
  input  logic [FW-1:0] load_val_i,
  output logic          unf_evt_o,
  output logic          werr_evt_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_MAX = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic [FW-1:0] cnt_q;
  logic          en, tick, reload_evt, last;

  assign en         = !mode_i.dis;
  assign reload_evt = enable_evt_i || restart_i;
  assign tick       = en && slow_en_i && (pre_q == PRE_MAX);
  assign last       = (cnt_q <= FW'(1));
  assign unf_evt_o  = tick && last && !reload_evt;
  assign werr_evt_o = restart_i && en && (cnt_q > mode_i.delta);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= MODE_RST.reload;
    end else if (reload_evt) begin
      pre_q <= '0;
      cnt_q <= load_val_i;
    end else if (en && slow_en_i) begin
      pre_q <= (pre_q == PRE_MAX) ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= last ? mode_i.reload : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status
  import wdog_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     unf_evt_i,
  input  logic     werr_evt_i,
  input  logic     hazard_evt_i,
  input  logic     rd_i,
  output wd_stat_t stat_o,
  output logic     rst_req_o,
  output logic     fault_o
);
  wd_stat_t st_q;
  logic     req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      req_q <= 1'b0;
    end else begin
      st_q.unf    <= unf_evt_i    || (st_q.unf    && !rd_i);
      st_q.werr   <= werr_evt_i   || (st_q.werr   && !rd_i);
      st_q.hazard <= hazard_evt_i || (st_q.hazard && !rd_i);
      req_q       <= unf_evt_i;
    end
  end

  assign stat_o    = st_q;
  assign rst_req_o = req_q;
  assign fault_o   = st_q.unf || st_q.werr;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned DIV      = 128,
  parameter logic [7:0]  KEY      = 8'hA5,
  parameter int unsigned HZ_TICKS = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slow_en_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        fault_o,
  output logic        rst_req_o
);
  wd_mode_t      mode;
  wd_stat_t      stat;
  logic          locked, enable_evt, restart, hazard_evt, stat_rd;
  logic          unf_evt, werr_evt;
  logic [FW-1:0] load_val;

  wdog_regs #(.KEY(KEY), .HZ_TICKS(HZ_TICKS)) u_regs (
    .clk_i, .rst_ni, .slow_en_i, .req_i, .we_i, .addr_i, .wdata_i,
    .mode_o(mode), .locked_o(locked), .enable_evt_o(enable_evt),
    .restart_o(restart), .load_val_o(load_val),
    .hazard_evt_o(hazard_evt), .stat_rd_o(stat_rd)
  );

  wdog_counter #(.DIV(DIV)) u_cnt (
    .clk_i, .rst_ni, .slow_en_i, .mode_i(mode),
    .enable_evt_i(enable_evt), .restart_i(restart), .load_val_i(load_val),
    .unf_evt_o(unf_evt), .werr_evt_o(werr_evt)
  );

  wdog_status u_stat (
    .clk_i, .rst_ni, .unf_evt_i(unf_evt), .werr_evt_i(werr_evt),
    .hazard_evt_i(hazard_evt), .rd_i(stat_rd), .stat_o(stat),
    .rst_req_o, .fault_o
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        A_MODE:  rdata_o = pack_mode(mode);
        A_STAT:  rdata_o = {29'b0, stat};
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     fault_o,
  input logic     rst_req_o,
  input logic     locked,
  input wd_mode_t mode
);
  AST_RST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R4
  AST_EXPIRY_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> fault_o); // R9
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> locked); // R6
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(mode)); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode.dis) |-> !rst_req_o); // R10
endmodule

bind keyed_wdog wdog_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fault_o(fault_o), .rst_req_o(rst_req_o),
  .locked(locked), .mode(mode)
);

// File: tb/test_keyed_wdog.sv
`timescale 1ns/1ps
module test_keyed_wdog;
  localparam int DIV = 2;

  logic        clk = 1'b0, rst_ni = 1'b0, slow_en = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        fault_o, rst_req_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  keyed_wdog #(.DIV(DIV)) i_keyed_wdog (
    .clk_i(clk), .rst_ni, .slow_en_i(slow_en), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o, .fault_o, .rst_req_o
  );

  always #10 clk = ~clk;

  initial forever begin
    @(posedge clk); #1 slow_en = ~slow_en;
  end

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_rel, m_dlt, m_dis, m_lock, m_cnt, m_pre, m_hz, m_rreq;
  int s_unf, s_werr, s_haz;

  function automatic logic [31:0] m_rdata();
    if (!(req && !we)) return 32'h0;
    if (addr == 2'd1) return {4'h0, m_dlt[11:0], m_dis[0], 3'b000, m_rel[11:0]};
    if (addr == 2'd2) return {29'h0, s_haz[0], s_werr[0], s_unf[0]};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rel = 'hFFF; m_dlt = 'hFFF; m_dis = 1; m_lock = 0;
      m_cnt = 'hFFF; m_pre = 0; m_hz = 3; m_rreq = 0;
      s_unf = 0; s_werr = 0; s_haz = 0;
    end else begin
      int rd, ctrl, kok, rs, lk, mw, nrel, ndis, ndlt, en, ena, tick, unf, werr, haz;
      cyc++;
      rd   = req && !we && addr == 2'd2;
      ctrl = req && we && addr == 2'd0;
      kok  = wdata[31:24] == 8'hA5;
      rs   = ctrl && kok && wdata[0];
      lk   = ctrl && kok && wdata[4];
      mw   = req && we && addr == 2'd1 && !m_lock;
      nrel = wdata[11:0]; ndis = wdata[15]; ndlt = wdata[27:16];
      en   = !m_dis;
      ena  = mw && m_dis && !ndis;
      tick = en && slow_en && m_pre == DIV - 1;
      unf  = tick && m_cnt <= 1 && !(ena || rs);
      werr = rs && en && m_cnt > m_dlt;
      haz  = mw && m_hz < 3 && (nrel != m_rel || ndlt != m_dlt);
      if (ena) begin m_cnt = nrel; m_pre = 0; end
      else if (rs) begin m_cnt = m_rel; m_pre = 0; end
      else if (en && slow_en) begin
        if (tick) m_cnt = (m_cnt <= 1) ? m_rel : m_cnt - 1;
        m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      end
      if (rs) m_hz = 0; else if (slow_en && m_hz < 3) m_hz++;
      if (mw) begin m_rel = nrel; m_dis = ndis; m_dlt = ndlt; end
      if (lk) m_lock = 1;
      s_unf  = unf  || (s_unf  && !rd);
      s_werr = werr || (s_werr && !rd);
      s_haz  = haz  || (s_haz  && !rd);
      m_rreq = unf;
    end
  end

  always @(negedge clk) begin
    check("R4 rst_req", rst_req_o, m_rreq);
    check("R9 fault", fault_o, s_unf || s_werr);
    check("R2 rdata", rdata_o, m_rdata());
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #1 req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 req = 0; we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1 req = 1; we = 0; addr = a;
    @(negedge clk); d = rdata_o;
    @(posedge clk); #1 req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic time_expiry(int exp_lo, int exp_hi, string rq);
    int n = 0;
    while (n < 400 && rst_req_o !== 1'b1) begin @(negedge clk); n++; end
    check(rq, (n >= exp_lo && n <= exp_hi), 1'b1);
  endtask

  initial begin
    logic [31:0] d;
    int got;
    #45 rst_ni = 1;
    // R1 reset state
    rd(2'd1, d); check("R1 mode reset", d, 32'h0FFF8FFF);
    rd(2'd2, d); check("R1 status reset", d, 32'h0);
    check("R1 fault reset", fault_o, 1'b0);
    // R2 layout
    wr(2'd1, 32'h01238456); rd(2'd1, d); check("R2 fields", d, 32'h01238456);
    wr(2'd1, 32'hF0FFFFFF); rd(2'd1, d); check("R2 other bits zero", d, 32'h00FF8FFF);
    rd(2'd3, d); check("R2 unused addr", d, 32'h0);
    // R3 enable after zero fields, R4 expiry timing
    wr(2'd1, 32'h00008000);
    idle(10);
    wr(2'd1, 32'h0FFF0005);
    time_expiry(5*2*DIV - 3, 5*2*DIV + 3, "R3 reload on enable");
    @(negedge clk); check("R4 fault after expiry", fault_o, 1'b1);
    rd(2'd2, d); check("R4 underflow bit", d[0], 1'b1);
    rd(2'd2, d); check("R9 clear on read", d & 32'h1, 32'h0);
    // R9 reads every cycle across an expiry
    for (int i = 0; i < 30; i++) rd(2'd2, d);
    // R10 disabled
    wr(2'd1, 32'h0FFF8005); rd(2'd2, d);
    got = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (rst_req_o) got = 1; end
    check("R10 no expiry while disabled", got, 0);
    rd(2'd2, d); check("R10 status quiet", d, 32'h0);
    // R5 keyed restart keeps it alive, bad key does not
    wr(2'd1, 32'h0FFF0005);
    got = 0;
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 32'hA5000001);
      repeat (8) begin @(negedge clk); if (rst_req_o) got = 1; end
    end
    check("R5 keyed restart holds off", got, 0);
    got = 0;
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 32'h5A000001);
      repeat (8) begin @(negedge clk); if (rst_req_o) got = 1; end
    end
    check("R5 bad key ignored", got, 1);
    // R7 window error
    wr(2'd1, 32'h0002000A); idle(10);
    wr(2'd0, 32'hA5000001); rd(2'd2, d);
    wr(2'd0, 32'hA5000001);
    @(negedge clk); check("R7 fault on window", fault_o, 1'b1);
    rd(2'd2, d); check("R7 window bit", d & 32'h2, 32'h2);
    // R8 hazard
    wr(2'd1, 32'h0FFF000A); idle(10); rd(2'd2, d);
    wr(2'd0, 32'hA5000001);
    wr(2'd1, 32'h0FFF000B);
    rd(2'd2, d); check("R8 hazard flagged", d, 32'h4);
    rd(2'd1, d); check("R8 write applied", d, 32'h0FFF000B);
    wr(2'd0, 32'hA5000001); idle(10);
    wr(2'd1, 32'h0FFF000C);
    rd(2'd2, d); check("R8 no hazard late", d, 32'h0);
    // R6 lock
    wr(2'd0, 32'h11000010); wr(2'd1, 32'h0FFF800C);
    rd(2'd1, d); check("R6 bad key lock ignored", d, 32'h0FFF800C);
    wr(2'd0, 32'hA5000010); wr(2'd1, 32'h01118111);
    rd(2'd1, d); check("R6 locked", d, 32'h0FFF800C);
    rst_ni = 0; idle(2); #1 rst_ni = 1;
    rd(2'd1, d); check("R1 mode after reset", d, 32'h0FFF8FFF);
    wr(2'd1, 32'h01118111); rd(2'd1, d); check("R6 unlocked by reset", d, 32'h01118111);
    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule